// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This block sits between a bus master and a byte-addressed memory port. It serves two alias windows in which every 32-bit alias word stands for one bit of an underlying real region. A read through an alias fetches the target byte, halfword or word and returns only the chosen bit, as 0 or 1. A write through an alias reads the target unit, sets or clears the chosen bit according to bit 0 of the write data, and writes the unit back with every other bit unchanged.

The master raises `s_valid` with a request and holds it until `s_ready` pulses for one cycle. At that pulse the answer is on `s_rdata`. On the memory side the block issues one access at a time and holds it until the memory raises `m_ready`. Read data comes back on `m_rdata` in the same cycle as `m_ready`. A request whose address lies outside both windows goes to memory unchanged.

Top module: `bb_bridge`

## Requirements
- R1: Alias addresses 0x22000000 to 0x23FFFFFF translate into the region based at 0x20000000, and 0x42000000 to 0x43FFFFFF into the region based at 0x40000000. The real address is the region base ORed with the low 25 bits of the alias address shifted right by 5.
- R2: The bit number within the unit is alias address bits [6:2], masked to 3 bits for bytes (`s_size`=0), to 4 bits for halfwords (`s_size`=1), and kept at 5 bits for words (`s_size`=2). Halfword real addresses have bit 0 cleared, and word real addresses have bits 1:0 cleared.
- R3: An alias read performs one memory read of the access size. It returns 1 on `s_rdata[0]` when the selected bit is set and 0 otherwise, with `s_rdata[31:1]` zero.
- R4: An alias write reads the unit first. It then writes it back with only the selected bit changed: set when `s_wdata[0]` is 1, cleared when it is 0. `s_wdata[31:1]` has no effect.
- R5: Memory is little-endian on a 32-bit bus. Bit k of a unit at address A is bus bit 8*((A + k/8) mod 4) + k mod 8. Byte enables cover exactly the unit: one lane for a byte (lane = address[1:0]), lanes 1:0 or 3:2 for a halfword (chosen by address bit 1), and all four lanes for a word.
- R6: `s_ready` is high for exactly one cycle per request, after the read and, for writes, the write-back have completed. While `m_valid` is high and `m_ready` low, the memory request stays unchanged.
- R7: A request outside both windows reaches memory with its own address, write data and access-size byte enables. A pass-through read returns the full `m_rdata` word.
- R8: A synchronous active-high reset returns the sequencer to idle within one clock. `m_valid` and `s_ready` are low in the cycle after reset, even if reset arrives in the middle of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Request present, held until s_ready |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | Request address |
| s_wdata | input | 32 | Write data (bit 0 only for alias writes) |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, valid with s_ready |
| m_valid | output | 1 | Memory access request |
| m_write | output | 1 | Memory access is a write |
| m_addr | output | 32 | Memory byte address |
| m_be | output | 4 | Memory byte-lane enables |
| m_wdata | output | 32 | Memory write data |
| m_ready | input | 1 | Memory completes the access this cycle |
| m_rdata | input | 32 | Memory read data, valid with m_ready |

## Verification
The assertions assume that the master holds `s_valid` and the request fields steady from the cycle it raises them until `s_ready` arrives, and that `s_size` never takes the value 3. They also take the memory's read data to be valid in the cycle `m_ready` is high. The bench's memory model answers every access one cycle after it appears, so every hold path is exercised. The bench drives one request at a time with only sizes 0 to 2, keeps the request fields fixed until it has seen `s_ready`, and drops `s_valid` on the same falling edge. The one exception is the mid-request reset, during which the assertions are disabled.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BUS_W         = 32;
    localparam int LANES         = BUS_W / 8;
    localparam int POS_W         = $clog2(BUS_W);
    localparam int SEL_SHIFT     = 2;
    localparam int WORD_SHIFT    = POS_W;
    localparam int NUM_WIN_DEF   = 2;
    localparam int SPAN_LOG2_DEF = 25;

    localparam logic [NUM_WIN_DEF-1:0][31:0] ALIAS_BASE_DEF = {32'h4200_0000, 32'h2200_0000};
    localparam logic [NUM_WIN_DEF-1:0][31:0] REAL_BASE_DEF  = {32'h4000_0000, 32'h2000_0000};

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } bb_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY_WRITE,
        ST_RESPOND
    } bb_state_e;

    typedef struct packed {
        logic             write;
        logic             hit;
        logic [31:0]      addr;
        logic [LANES-1:0] be;
        logic [POS_W-1:0] pos;
        logic [BUS_W-1:0] wdata;
    } bb_req_t;

    // lane enables for a unit of the given size at the given low address bits
    function automatic logic [LANES-1:0] lane_be(input bb_size_e size, input logic [1:0] lo);
        case (size)
            SZ_BYTE: lane_be = LANES'(1) << lo;
            SZ_HALF: lane_be = {{2{lo[1]}}, {2{~lo[1]}}};
            default: lane_be = '1;
        endcase
    endfunction

    // position on the little-endian bus of bit "sel" of the unit at "lo"
    function automatic logic [POS_W-1:0] bus_pos(input bb_size_e size, input logic [1:0] lo,
                                                 input logic [POS_W-1:0] sel);
        case (size)
            SZ_BYTE: bus_pos = {lo, sel[2:0]};
            SZ_HALF: bus_pos = {lo[1], sel[3:0]};
            default: bus_pos = sel;
        endcase
    endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter int NUM_WIN   = NUM_WIN_DEF,
    parameter int SPAN_LOG2 = SPAN_LOG2_DEF,
    parameter logic [NUM_WIN-1:0][31:0] ALIAS_BASE = ALIAS_BASE_DEF,
    parameter logic [NUM_WIN-1:0][31:0] REAL_BASE  = REAL_BASE_DEF
) (
    input  logic        write,
    input  logic [1:0]  size,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output bb_req_t     req
);
    logic [NUM_WIN-1:0]       hit;
    logic [NUM_WIN-1:0][31:0] cand;
    logic [31:0]              real_a;
    logic                     any_hit;
    logic [POS_W-1:0]         sel;
    bb_size_e                 sz;

    assign sz = bb_size_e'(size);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign hit[w]  = addr[31:SPAN_LOG2] == ALIAS_BASE[w][31:SPAN_LOG2];
        assign cand[w] = REAL_BASE[w] | 32'(addr[SPAN_LOG2-1:0] >> WORD_SHIFT);
    end

    always_comb begin
        real_a  = addr;
        any_hit = 1'b0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                any_hit = 1'b1;
                real_a  = cand[w];
            end
        end
        if (any_hit) begin
            if (sz == SZ_HALF) real_a[0] = 1'b0;
            if (sz != SZ_BYTE && sz != SZ_HALF) real_a[1:0] = 2'b00;
        end
        sel = addr[SEL_SHIFT +: POS_W];
        case (sz)
            SZ_BYTE: sel = sel & POS_W'(7);
            SZ_HALF: sel = sel & POS_W'(15);
            default: ;
        endcase
    end

    assign req.write = write;
    assign req.hit   = any_hit;
    assign req.addr  = real_a;
    assign req.be    = lane_be(sz, real_a[1:0]);
    assign req.pos   = bus_pos(sz, real_a[1:0], sel);
    assign req.wdata = wdata;

endmodule

// File: rtl/bb_modify.sv
module bb_modify
    import bb_pkg::*;
(
    input  logic [BUS_W-1:0] rdata,
    input  logic [POS_W-1:0] pos,
    input  logic             set_val,
    output logic [BUS_W-1:0] merged,
    output logic             bit_val
);
    logic [BUS_W-1:0] mask;

    assign mask    = BUS_W'(1) << pos;
    assign bit_val = |(rdata & mask);
    assign merged  = set_val ? (rdata | mask) : (rdata & ~mask);

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      s_valid,
    input  logic      in_write,
    input  logic      in_hit,
    input  logic      q_write,
    input  logic      q_hit,
    input  logic      m_ready,
    output logic      accept,
    output bb_state_e state
);
    bb_state_e nxt;

    assign accept = (state == ST_IDLE) && s_valid;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (s_valid) nxt = (in_write && !in_hit) ? ST_MODIFY_WRITE : ST_READ;
            end
            ST_READ: begin
                if (m_ready) nxt = (q_write && q_hit) ? ST_MODIFY_WRITE : ST_RESPOND;
            end
            ST_MODIFY_WRITE: begin
                if (m_ready) nxt = ST_RESPOND;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
    import bb_pkg::*;
#(
    parameter int NUM_WIN   = NUM_WIN_DEF,
    parameter int SPAN_LOG2 = SPAN_LOG2_DEF,
    parameter logic [NUM_WIN-1:0][31:0] ALIAS_BASE = ALIAS_BASE_DEF,
    parameter logic [NUM_WIN-1:0][31:0] REAL_BASE  = REAL_BASE_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_valid,
    input  logic        s_write,
    input  logic [1:0]  s_size,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic [31:0] s_rdata,
    output logic        m_valid,
    output logic        m_write,
    output logic [31:0] m_addr,
    output logic [3:0]  m_be,
    output logic [31:0] m_wdata,
    input  logic        m_ready,
    input  logic [31:0] m_rdata
);
    bb_req_t          dec;
    bb_req_t          req_q;
    logic [BUS_W-1:0] rd_q;
    logic [BUS_W-1:0] merged;
    logic             bit_val;
    logic             accept;
    bb_state_e        state;

    bb_decode #(
        .NUM_WIN   (NUM_WIN),
        .SPAN_LOG2 (SPAN_LOG2),
        .ALIAS_BASE(ALIAS_BASE),
        .REAL_BASE (REAL_BASE)
    ) u_dec (
        .write(s_write),
        .size (s_size),
        .addr (s_addr),
        .wdata(s_wdata),
        .req  (dec)
    );

    bb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .s_valid (s_valid),
        .in_write(dec.write),
        .in_hit  (dec.hit),
        .q_write (req_q.write),
        .q_hit   (req_q.hit),
        .m_ready (m_ready),
        .accept  (accept),
        .state   (state)
    );

    bb_modify u_mod (
        .rdata  (rd_q),
        .pos    (req_q.pos),
        .set_val(req_q.wdata[0]),
        .merged (merged),
        .bit_val(bit_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            rd_q  <= '0;
        end else begin
            if (accept) req_q <= dec;
            if (state == ST_READ && m_ready) rd_q <= m_rdata;
        end
    end

    assign m_valid = (state == ST_READ) || (state == ST_MODIFY_WRITE);
    assign m_write = (state == ST_MODIFY_WRITE);
    assign m_addr  = req_q.addr;
    assign m_be    = req_q.be;
    assign m_wdata = req_q.hit ? merged : req_q.wdata;
    assign s_ready = (state == ST_RESPOND);
    assign s_rdata = req_q.hit ? {{(BUS_W-1){1'b0}}, bit_val} : rd_q;

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk
    import bb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        s_valid,
    input logic        s_write,
    input logic [1:0]  s_size,
    input logic [31:0] s_addr,
    input logic [31:0] s_wdata,
    input logic        s_ready,
    input logic [31:0] s_rdata,
    input logic        m_valid,
    input logic        m_write,
    input logic [31:0] m_addr,
    input logic [3:0]  m_be,
    input logic [31:0] m_wdata,
    input logic        m_ready,
    input logic [31:0] m_rdata
);
    localparam int TOP_W = 32 - SPAN_LOG2_DEF;

    logic             in_win;
    logic [TOP_W-1:0] real_top;
    logic             alias_req;
    logic [31:0]      seen_rd;
    int               lanes_exp;

    always_comb begin
        in_win   = 1'b0;
        real_top = '0;
        for (int w = NUM_WIN_DEF - 1; w >= 0; w--) begin
            if (s_addr[31:SPAN_LOG2_DEF] == ALIAS_BASE_DEF[w][31:SPAN_LOG2_DEF]) begin
                in_win   = 1'b1;
                real_top = REAL_BASE_DEF[w][31:SPAN_LOG2_DEF];
            end
        end
        lanes_exp = (s_size == 2'd0) ? 1 : (s_size == 2'd1) ? 2 : 4;
    end

    assign alias_req = s_valid && in_win;

    always_ff @(posedge clk) begin
        if (rst) seen_rd <= '0;
        else if (m_valid && m_ready && !m_write) seen_rd <= m_rdata;
    end

    p_window_r1: assert property (@(posedge clk) disable iff (rst)
        m_valid && alias_req |-> m_addr[31:SPAN_LOG2_DEF] == real_top);

    p_read_onebit_r3: assert property (@(posedge clk) disable iff (rst)
        s_ready && alias_req && !s_write |-> s_rdata[31:1] == 31'd0);

    p_write_onebit_r4: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_write && alias_req |-> $countones(m_wdata ^ seen_rd) <= 1);

    p_lane_count_r5: assert property (@(posedge clk) disable iff (rst)
        m_valid && s_valid |-> $countones(m_be) == lanes_exp);

    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    p_mem_hold_r6: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_be));

    p_pass_addr_r7: assert property (@(posedge clk) disable iff (rst)
        m_valid && s_valid && !in_win |-> m_addr == s_addr);

    p_pass_data_r7: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_write && s_valid && !in_win |-> m_wdata == s_wdata);

    p_reset_idle_r8: assert property (@(posedge clk)
        $past(rst) |-> !m_valid && !s_ready);

endmodule

bind bb_bridge bb_bridge_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .s_valid(s_valid),
    .s_write(s_write),
    .s_size (s_size),
    .s_addr (s_addr),
    .s_wdata(s_wdata),
    .s_ready(s_ready),
    .s_rdata(s_rdata),
    .m_valid(m_valid),
    .m_write(m_write),
    .m_addr (m_addr),
    .m_be   (m_be),
    .m_wdata(m_wdata),
    .m_ready(m_ready),
    .m_rdata(m_rdata)
);

// File: tb/sim_bb_bridge.sv
module sim_bb_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_write = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = 32'd0;
    logic [31:0] s_wdata = 32'd0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_valid;
    logic        m_write;
    logic [31:0] m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wdata;
    logic        m_ready;
    logic [31:0] m_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] mem [256];
    logic [31:0] shadow [256];
    logic [31:0] rec_raddr, rec_waddr, rec_wdata;
    logic [3:0]  rec_rbe, rec_wbe;

    always #10 clk = ~clk;

    bb_bridge u0 (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_write(s_write), .s_size(s_size), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_be(m_be),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    function automatic int midx(input logic [31:0] a);
        return int'({a[30], a[8:2]});
    endfunction

    function automatic logic [31:0] init_word(input int i);
        return 32'hC3A5_5A3C ^ (32'(i) * 32'h0101_0107);
    endfunction

    assign m_rdata = mem[midx(m_addr)];

    // memory model: answers each access one cycle after it appears
    always @(posedge clk) begin
        if (rst) begin
            m_ready <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
        end else begin
            m_ready <= m_valid && !m_ready;
            if (m_valid && m_ready) begin
                if (m_write) begin
                    rec_waddr <= m_addr;
                    rec_wbe   <= m_be;
                    rec_wdata <= m_wdata;
                    for (int l = 0; l < 4; l++)
                        if (m_be[l]) mem[midx(m_addr)][l*8 +: 8] <= m_wdata[l*8 +: 8];
                end else begin
                    rec_raddr <= m_addr;
                    rec_rbe   <= m_be;
                end
            end
        end
    end

    // expected values, derived from the requirements
    function automatic logic [31:0] exp_real(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] r;
        r = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
        r = r | ({7'd0, a[24:0]} >> 5);
        if (sz == 2'd1) r[0] = 1'b0;
        if (sz == 2'd2) r[1:0] = 2'b00;
        return r;
    endfunction

    function automatic int exp_pos(input logic [31:0] a, input logic [1:0] sz);
        int k;
        logic [31:0] b;
        k = (sz == 2'd0) ? int'(a[4:2]) : (sz == 2'd1) ? int'(a[5:2]) : int'(a[6:2]);
        b = exp_real(a, sz) + 32'(k / 8);
        return int'(b[1:0]) * 8 + (k % 8);
    endfunction

    function automatic logic [3:0] exp_be(input logic [31:0] r, input logic [1:0] sz);
        if (sz == 2'd0) return 4'b0001 << r[1:0];
        if (sz == 2'd1) return r[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        int n;
        @(negedge clk);
        s_valid = 1'b1; s_write = wr; s_size = sz; s_addr = a; s_wdata = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!s_ready && n < 60);
        if (!s_ready) chk(1'b0, "R6 request timed out", 32'(n), 32'd60);
        rd = s_rdata;
        s_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] wd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'd0, 32'h2200_0000, 32'h0000_0000},
        '{1'b1, 2'd0, 32'h2200_0004, 32'h0000_0001},
        '{1'b0, 2'd0, 32'h2200_0004, 32'h0000_0000},
        '{1'b0, 2'd1, 32'h2200_0064, 32'h0000_0000},
        '{1'b1, 2'd1, 32'h2200_0064, 32'h0000_0000},
        '{1'b0, 2'd1, 32'h2200_0064, 32'h0000_0000},
        '{1'b1, 2'd2, 32'h4200_007C, 32'h0000_0001},
        '{1'b0, 2'd2, 32'h4200_007C, 32'h0000_0000},
        '{1'b1, 2'd2, 32'h4200_0080, 32'hFFFF_FFFE},
        '{1'b0, 2'd2, 32'h4200_0080, 32'h0000_0000},
        '{1'b1, 2'd0, 32'h4200_016C, 32'h0000_0003},
        '{1'b0, 2'd0, 32'h4200_016C, 32'h0000_0000}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            chk(1'b0, "watchdog expired", 32'(cyc), 32'd20000);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd, r, w;
        int p;
        for (int i = 0; i < 256; i++) shadow[i] = init_word(i);

        // R8: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!m_valid && !s_ready, "R8 idle after reset", {m_valid, s_ready}, 32'd0);

        // table of alias accesses
        for (int v = 0; v < NV; v++) begin
            r = exp_real(VT[v].a, VT[v].sz);
            p = exp_pos(VT[v].a, VT[v].sz);
            access(VT[v].wr, VT[v].sz, VT[v].a, VT[v].wd, rd);
            chk(rec_raddr == r, "R1 R2 real address", rec_raddr, r);
            chk(rec_rbe == exp_be(r, VT[v].sz), "R5 byte enables", 32'(rec_rbe), 32'(exp_be(r, VT[v].sz)));
            if (VT[v].wr) begin
                w = shadow[midx(r)];
                w[p] = VT[v].wd[0];
                shadow[midx(r)] = w;
                @(negedge clk);
                chk(mem[midx(r)] == w, "R4 write changes only one bit", mem[midx(r)], w);
            end else begin
                w = {31'd0, shadow[midx(r)][p]};
                chk(rd == w, "R3 alias read bit", rd, w);
            end
        end

        // R4: upper write-data bits ignored: 0xFFFFFFFE clears, 0x00000002 clears
        access(1'b1, 2'd2, 32'h4200_007C, 32'h0000_0002, rd);
        access(1'b0, 2'd2, 32'h4200_007C, 32'h0, rd);
        chk(rd == 32'd0, "R4 upper data bits ignored", rd, 32'd0);

        // R6: ready lasts one cycle
        @(negedge clk);
        chk(!s_ready, "R6 ready single pulse", {31'd0, s_ready}, 32'd0);

        // R1: top of the first window
        access(1'b0, 2'd0, 32'h23FF_FFFC, 32'h0, rd);
        chk(rec_raddr == 32'h200F_FFFF, "R1 window top address", rec_raddr, 32'h200F_FFFF);

        // R7: pass-through write and reads
        access(1'b1, 2'd2, 32'h2000_0010, 32'hDEAD_BEEF, rd);
        chk(rec_waddr == 32'h2000_0010, "R7 pass-through address", rec_waddr, 32'h2000_0010);
        chk(rec_wdata == 32'hDEAD_BEEF, "R7 pass-through data", rec_wdata, 32'hDEAD_BEEF);
        chk(rec_wbe == 4'hF, "R7 pass-through enables", 32'(rec_wbe), 32'hF);
        access(1'b0, 2'd2, 32'h2000_0010, 32'h0, rd);
        chk(rd == 32'hDEAD_BEEF, "R7 pass-through read word", rd, 32'hDEAD_BEEF);
        access(1'b0, 2'd0, 32'h21FF_FE01, 32'h0, rd);
        chk(rec_raddr == 32'h21FF_FE01, "R7 below window passes", rec_raddr, 32'h21FF_FE01);
        chk(rec_rbe == 4'b0010, "R5 R7 byte lane", 32'(rec_rbe), 32'h2);

        // R8: reset in the middle of a request
        @(negedge clk);
        s_valid = 1'b1; s_write = 1'b1; s_size = 2'd0; s_addr = 32'h2200_0008; s_wdata = 32'h1;
        @(negedge clk);
        chk(m_valid, "R8 request started", {31'd0, m_valid}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(!m_valid && !s_ready, "R8 mid-request reset", {m_valid, s_ready}, 32'd0);
        rst = 1'b0;
        s_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!m_valid && !s_ready, "R8 stays idle", {m_valid, s_ready}, 32'd0);

        finish_run();
    end

endmodule